// File: doc/BRIEF.md
# Shift Unit with Carry-Out for Register and Immediate Amounts

This block is a purely combinational 32-bit shifter for an integer execution stage. It performs a logical shift left, a logical shift right or an arithmetic shift right on one operand. Alongside the shifted value it produces the shifter carry-out, which is the last bit moved out of the word.

The shift distance comes from one of two sources. The first is a general register value, of which only the low byte counts, so distances from 0 to 255 are all defined. The second is a 5-bit field taken from an instruction word. In the immediate field, a code of zero means a shift by 32 for the two right shifts and no shift for the left shift.

The rules for large distances are strict. A distance of exactly the word width still moves one operand bit into the carry. Distances beyond the width clear the result and the carry, except for the arithmetic shift, which keeps the sign. When no shift takes place, the incoming carry flag passes through unchanged. The consumer latches `result` and `carryOut` in its own pipeline register.

Top module: `carry_barrel_shifter`

## Requirements
- R1: When the effective distance is 0, `result` equals `operand` and `carryOut` equals `carryIn`, for every shift type.
- R2: With `useImm`=0 the distance is `regAmount[7:0]`, and all higher bits are ignored; for example, 256 acts as a shift of 0.
- R3: Left shift (type 2'b00) by n in 1..31 gives `operand << n` with `carryOut` = `operand[32-n]`.
- R4: Logical right shift (type 2'b01) by n in 1..31 gives `operand >> n` with zeros filled in at the top and `carryOut` = `operand[n-1]`.
- R5: Arithmetic right shift (type 2'b10) by n in 1..31 fills the vacated top bits with `operand[31]`, with `carryOut` = `operand[n-1]`.
- R6: Left shift by exactly 32 gives 0 with `carryOut` = `operand[0]`; by 33 or more it gives 0 with `carryOut` = 0.
- R7: Logical right shift by exactly 32 gives 0 with `carryOut` = `operand[31]`; by 33 or more it gives 0 with `carryOut` = 0.
- R8: Arithmetic right shift by 32 or more sets every result bit and `carryOut` to `operand[31]`.
- R9: With `useImm`=1 the distance is `immAmount`, except that a code of 0 means 32 for types 2'b01 and 2'b10; for type 2'b00 a code of 0 means no shift.
- R10: Type 2'b11 is reserved: `result` equals `operand` and `carryOut` equals `carryIn`, whatever the distance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand | input | 32 | Value to be shifted |
| shiftType | input | 2 | 00 left, 01 logical right, 10 arithmetic right, 11 reserved |
| regAmount | input | 32 | Register-sourced distance; only bits 7:0 are used |
| immAmount | input | 5 | Immediate-sourced distance code |
| useImm | input | 1 | 1 selects `immAmount`, 0 selects `regAmount` |
| carryIn | input | 1 | Current carry flag, passed through when nothing shifts |
| result | output | 32 | Shifted value |
| carryOut | output | 1 | Shifter carry-out |

## Verification
The block holds no state. A wrong internal decision therefore shows at the ports in the same evaluation as the stimulus that causes it, and it disappears with the next input change.

The decisions that can go wrong are the distance decode, the over-range flags and the choice of fill bit. A wrong distance decode appears as a result moved by the wrong number of places, most visibly at 0, 32, 33 and 256. A wrong over-range flag or fill choice appears as a wrong carry or as wrong top bits.

The bench sweeps every register distance from 0 to 300 and every immediate code for each type and several operand patterns. Each combination is compared in the clock cycle it is applied, so any such fault is caught on the first vector that exposes it.

// File: rtl/shifter_pkg.sv
package shifter_pkg;

  typedef enum logic [1:0] {
    SHT_LSL  = 2'b00,
    SHT_LSR  = 2'b01,
    SHT_ASR  = 2'b10,
    SHT_RSVD = 2'b11
  } shift_kind_e;

  localparam int unsigned WORD_W  = 32;
  localparam int unsigned STAGE_N = $clog2(WORD_W);

  // Strobes from the decode logic to the shifting datapath
  typedef struct packed {
    logic                     passThru;   // nothing moves: operand and carry pass
    logic                     goRight;    // right shift (done on the reversed word)
    logic                     arithFill;  // vacated bits take the sign bit
    logic                     overRange;  // distance >= word width
    logic                     atWidth;    // distance == word width exactly
    logic [STAGE_N-1:0]       stageAmt;   // distance modulo word width
  } shift_ctrl_t;

endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shifter_pkg::*;
#(
  parameter int unsigned WIDTH  = WORD_W,
  parameter int unsigned REG_W  = 32,
  parameter int unsigned AMT_W  = 8,
  parameter int unsigned IMM_W  = 5
) (
  input  logic [1:0]       shiftType,
  input  logic [REG_W-1:0] regAmount,
  input  logic [IMM_W-1:0] immAmount,
  input  logic             useImm,
  output shift_ctrl_t      ctrl
);

  localparam int unsigned SH_W = $clog2(WIDTH);

  shift_kind_e kind;
  logic [AMT_W-1:0] effAmt;
  logic immZeroRight;

  always_comb begin
    kind = shift_kind_e'(shiftType);
    immZeroRight = (immAmount == '0) && (kind == SHT_LSR || kind == SHT_ASR);
    if (useImm) begin
      if (immZeroRight) effAmt = AMT_W'(WIDTH);
      else              effAmt = AMT_W'(immAmount);
    end else begin
      effAmt = regAmount[AMT_W-1:0];
    end

    ctrl.passThru  = (effAmt == '0) || (kind == SHT_RSVD);
    ctrl.goRight   = (kind == SHT_LSR) || (kind == SHT_ASR);
    ctrl.arithFill = (kind == SHT_ASR);
    ctrl.overRange = (effAmt >= AMT_W'(WIDTH));
    ctrl.atWidth   = (effAmt == AMT_W'(WIDTH));
    ctrl.stageAmt  = effAmt[SH_W-1:0];
  end

  // An immediate code of zero on a right shift must select a full-width shift
  always_comb begin
    if (useImm && immAmount == '0 && shiftType inside {2'b01, 2'b10})
      assert_imm_zero_full_R9: assert (!ctrl.passThru && ctrl.atWidth && ctrl.overRange)
        else $error("R9: immediate zero on right shift not decoded as full width");
  end

  // An in-range nonzero distance never sets the over-range strobes
  always_comb begin
    if (!ctrl.overRange)
      assert_range_strobes_R6: assert (!ctrl.atWidth)
        else $error("R6: width strobe set while in range");
  end

endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shifter_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W
) (
  input  logic [WIDTH-1:0] operand,
  input  logic             carryIn,
  input  shift_ctrl_t      ctrl,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  localparam int unsigned SH_W = $clog2(WIDTH);

  logic [WIDTH-1:0] revOp;
  logic [WIDTH-1:0] revBack;
  logic             fillBit;
  logic             signBit;
  logic [SH_W:0][WIDTH:0] stage;
  logic [WIDTH-1:0] smallRes;

  assign signBit = operand[WIDTH-1];
  assign fillBit = ctrl.arithFill & signBit;

  // Bit reversal lets a single left-moving barrel serve both directions
  generate
    for (genvar b = 0; b < WIDTH; b++) begin : g_rev
      assign revOp[b] = operand[WIDTH-1-b];
    end
  endgenerate

  // The extra top bit collects the last bit moved out: that is the carry
  assign stage[0] = {1'b0, (ctrl.goRight ? revOp : operand)};

  generate
    for (genvar i = 0; i < SH_W; i++) begin : g_stage
      localparam int unsigned STEP = 2 ** i;
      assign stage[i+1] = ctrl.stageAmt[i]
                        ? {stage[i][WIDTH-STEP:0], {STEP{fillBit}}}
                        : stage[i];
    end
    for (genvar b = 0; b < WIDTH; b++) begin : g_unrev
      assign revBack[b] = stage[SH_W][WIDTH-1-b];
    end
  endgenerate

  assign smallRes = ctrl.goRight ? revBack : stage[SH_W][WIDTH-1:0];

  always_comb begin
    if (ctrl.passThru) begin
      result   = operand;
      carryOut = carryIn;
    end else if (!ctrl.overRange) begin
      result   = smallRes;
      carryOut = stage[SH_W][WIDTH];
    end else if (ctrl.arithFill) begin
      result   = {WIDTH{signBit}};
      carryOut = signBit;
    end else begin
      result   = '0;
      carryOut = ctrl.atWidth & (ctrl.goRight ? signBit : operand[0]);
    end
  end

  always_comb begin
    if (!ctrl.passThru && !ctrl.goRight && !ctrl.overRange)
      assert_left_zero_fill_R3: assert (result[0] == 1'b0)
        else $error("R3: left shift did not fill bit 0 with zero");
    if (!ctrl.passThru && ctrl.goRight && !ctrl.arithFill && !ctrl.overRange)
      assert_right_zero_top_R4: assert (result[WIDTH-1] == 1'b0)
        else $error("R4: logical right shift left the top bit set");
    if (!ctrl.passThru && ctrl.arithFill)
      assert_sign_kept_R5: assert (result[WIDTH-1] == operand[WIDTH-1])
        else $error("R5: arithmetic shift lost the sign");
    if (!ctrl.passThru && !ctrl.arithFill && ctrl.overRange && !ctrl.atWidth)
      assert_far_clear_R7: assert (result == '0 && carryOut == 1'b0)
        else $error("R7: distance beyond width did not clear result and carry");
  end

endmodule

// File: rtl/carry_barrel_shifter.sv
module carry_barrel_shifter
  import shifter_pkg::*;
#(
  parameter int unsigned WIDTH = WORD_W,
  parameter int unsigned REG_W = 32,
  parameter int unsigned AMT_W = 8,
  parameter int unsigned IMM_W = 5
) (
  input  logic [WIDTH-1:0] operand,
  input  logic [1:0]       shiftType,
  input  logic [REG_W-1:0] regAmount,
  input  logic [IMM_W-1:0] immAmount,
  input  logic             useImm,
  input  logic             carryIn,
  output logic [WIDTH-1:0] result,
  output logic             carryOut
);

  shift_ctrl_t ctrlBus;

  shift_ctrl #(
    .WIDTH(WIDTH), .REG_W(REG_W), .AMT_W(AMT_W), .IMM_W(IMM_W)
  ) u_ctrl (
    .shiftType(shiftType),
    .regAmount(regAmount),
    .immAmount(immAmount),
    .useImm   (useImm),
    .ctrl     (ctrlBus)
  );

  shift_datapath #(.WIDTH(WIDTH)) u_dp (
    .operand (operand),
    .carryIn (carryIn),
    .ctrl    (ctrlBus),
    .result  (result),
    .carryOut(carryOut)
  );

  always_comb begin
    if (shiftType == 2'b11)
      assert_reserved_pass_R10: assert (result == operand && carryOut == carryIn)
        else $error("R10: reserved type altered operand or carry");
  end

endmodule

// File: tb/carry_barrel_shifter_test.sv
module carry_barrel_shifter_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 200000;

  logic        clk = 1'b0;
  logic [31:0] operand = '0;
  logic [1:0]  shiftType = '0;
  logic [31:0] regAmount = '0;
  logic [4:0]  immAmount = '0;
  logic        useImm = 1'b0;
  logic        carryIn = 1'b0;
  logic [31:0] result;
  logic        carryOut;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  carry_barrel_shifter uut (
    .operand(operand), .shiftType(shiftType), .regAmount(regAmount),
    .immAmount(immAmount), .useImm(useImm), .carryIn(carryIn),
    .result(result), .carryOut(carryOut)
  );

  // Behavioural reference: shift inside a 64-bit window and read the
  // neighbouring bit as the carry.
  task automatic model(input logic [31:0] op, input int typ, input int amt,
                       input logic cin, output logic [31:0] expR,
                       output logic expC, output string tag);
    logic [63:0] win;
    logic signed [63:0] swin;
    if (typ == 3) begin
      expR = op; expC = cin; tag = "R10";
    end else if (amt == 0) begin
      expR = op; expC = cin; tag = "R1";
    end else if (typ == 0) begin
      win = {32'b0, op} << amt;
      expR = win[31:0]; expC = win[32];
      tag = (amt < 32) ? "R3" : "R6";
    end else if (typ == 1) begin
      win = {op, 32'b0} >> amt;
      expR = win[63:32]; expC = win[31];
      tag = (amt < 32) ? "R4" : "R7";
    end else begin
      swin = $signed({op, 32'b0}) >>> amt;
      expR = swin[63:32]; expC = swin[31];
      tag = (amt < 32) ? "R5" : "R8";
    end
  endtask

  task automatic apply_and_check(input logic [31:0] op, input int typ,
                                 input logic [31:0] ra, input int imm,
                                 input logic ui, input logic cin,
                                 input string extraTag);
    logic [31:0] expR;
    logic expC;
    string tag;
    int amt;
    @(negedge clk);
    operand = op; shiftType = 2'(typ); regAmount = ra;
    immAmount = 5'(imm); useImm = ui; carryIn = cin;
    if (ui) amt = (imm == 0 && (typ == 1 || typ == 2)) ? 32 : imm;
    else    amt = int'(ra[7:0]);
    model(op, typ, amt, cin, expR, expC, tag);
    @(posedge clk);
    #1;
    checks++;
    if (result !== expR || carryOut !== expC) begin
      errors++;
      $display("FAIL %s%s type=%0d reg=%h imm=%0d useImm=%0b op=%h: got %h/%0b expected %h/%0b",
               tag, extraTag, typ, ra, imm, ui, op, result, carryOut, expR, expC);
    end
  endtask

  initial begin
    #(CLK_PERIOD * MAX_CYCLES);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [5];
    pats[0] = 32'hFFFF_FFFF;
    pats[1] = 32'hFFFF_FFFE;
    pats[2] = 32'h8000_0001;
    pats[3] = 32'h7A5C_3E91;
    pats[4] = 32'h0000_0001;

    // Idle state: all-zero inputs give zero result, zero carry (R1)
    @(posedge clk);
    #1;
    checks++;
    if (result !== 32'h0 || carryOut !== 1'b0) begin
      errors++;
      $display("FAIL R1 idle: got %h/%0b expected 00000000/0", result, carryOut);
    end

    // Register-sourced sweep 0..300: covers R1, R3..R8 and the wrap at 256
    // (R2); upper register bits are set to show they are ignored (R2).
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 5; p++)
        for (int a = 0; a <= 300; a++) begin
          apply_and_check(pats[p], t, 32'(a), 0, 1'b0, a[0], (a > 255) ? "/R2" : "");
          if (a % 37 == 0)
            apply_and_check(pats[p], t, 32'hABCD_0000 | 32'(a), 0, 1'b0, ~a[0], "/R2");
        end

    // Immediate-sourced codes 0..31 for each type (R9)
    for (int t = 0; t < 4; t++)
      for (int p = 0; p < 5; p++)
        for (int c = 0; c < 32; c++)
          apply_and_check(pats[p], t, 32'hFFFF_FFFF, c, 1'b1, c[1], "/R9");

    // Named corners: exact width and one beyond, both carry polarities
    apply_and_check(32'hFFFF_FFFF, 0, 32'd32, 0, 1'b0, 1'b0, "/R6");
    apply_and_check(32'hFFFF_FFFF, 0, 32'd33, 0, 1'b0, 1'b1, "/R6");
    apply_and_check(32'hFFFF_FFFF, 1, 32'd32, 0, 1'b0, 1'b0, "/R7");
    apply_and_check(32'hFFFF_FFFF, 1, 32'd33, 0, 1'b0, 1'b1, "/R7");
    apply_and_check(32'h8000_0000, 2, 32'd33, 0, 1'b0, 1'b0, "/R8");
    apply_and_check(32'h7FFF_FFFF, 2, 32'd200, 0, 1'b0, 1'b1, "/R8");
    apply_and_check(32'h1234_5678, 3, 32'd5, 0, 1'b0, 1'b1, "/R10");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule